// File: doc/BRIEF.md
# Fractional Accumulator Store Rounder

This block takes a 48-bit fractional accumulator word and produces the value that a store-to-register operation writes: either a 32-bit fraction or a 16-bit fraction. The top 8 bits of the accumulator are guard (extension) bits and the next 40 bits hold the fraction. A per-transfer size bit selects the result width. The bits below the kept field are discarded with round-to-nearest, ties-to-even rounding. A result that does not fit the chosen width is clamped to the largest positive or negative fraction, and an overflow flag is raised.

Both sides of the block use a valid/ready stream with one output register stage. An input is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the output registers at the next edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a full-rate stream passes with no bubbles. When `out_ready` is low while `out_valid` is high, the block holds its output unchanged and drops `in_ready`. The upstream stage must then keep its word and size bit stable until the word is accepted.

Top module: `acc_store_rounder`

## Requirements
- R1: With `in_narrow` = 0, the result is the 32-bit field at accumulator bits [39:8], rounded using bits [7:0].
- R2: With `in_narrow` = 1, the result is the 16-bit field at accumulator bits [39:24], rounded using bits [23:0].
- R3: A discarded field below one half of the kept field's LSB (below 0x80 or 0x800000) leaves the kept field unchanged.
- R4: A discarded field above one half adds one to the kept field.
- R5: A discarded field of exactly one half (0x80 or 0x800000) adds one only when the kept field's LSB is 1, so the result is even.
- R6: If the rounded value exceeds the largest positive fraction, the output is 0x7FFFFFFF (32-bit mode) or 0x00007FFF (16-bit mode), and `out_ovf` = 1. This covers both guard bits that are not a sign extension and overflow caused by rounding.
- R7: If the rounded value is below the most negative fraction, the output is 0x80000000 or 0xFFFF8000, and `out_ovf` = 1. When the value fits, `out_ovf` = 0.
- R8: In 16-bit mode, `out_data[31:16]` repeats `out_data[15]`.
- R9: A word accepted on one edge is presented with `out_valid` = 1 after that edge. Results leave in the order their inputs were accepted.
- R10: While `out_valid` = 1 and `out_ready` = 0, `out_data` and `out_ovf` stay stable and `in_ready` = 0.
- R11: During and just after reset, `out_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word can be taken this cycle |
| in_acc | input | 48 | Accumulator value: 8 guard bits over a 40-bit fraction |
| in_narrow | input | 1 | 1 selects a 16-bit result, 0 selects a 32-bit result |
| out_valid | output | 1 | Result held on the output |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_data | output | 32 | Rounded, clamped result (16-bit results sign-extended) |
| out_ovf | output | 1 | Result was clamped |

## Verification
The only state in the block is one output register and its valid bit. A wrong value there shows up at the ports in the first cycle after acceptance: either the data differs from the reference or `out_valid` disagrees with the model's queue occupancy. A valid bit that is lost or stuck under back-pressure shows as a missing or duplicated result within one cycle. Rounding faults only appear for particular discarded-field patterns, so the exact-half, half±1 and odd/even kept cases are driven directly for both sizes.

// File: rtl/ars_pkg.sv
package ars_pkg;
  typedef enum logic {
    RS_WIDE   = 1'b0,
    RS_NARROW = 1'b1
  } rsize_e;

  localparam int unsigned RS_LANES = 2;
endpackage

// File: rtl/ars_rne.sv
// Round-to-nearest-even of a signed word at a fixed cut point.
// Output is one bit wider than the kept field so a carry is never lost.
module ars_rne #(
  parameter int IN_W   = 48,
  parameter int DROP_W = 8
) (
  input  logic [IN_W-1:0]        din,
  output logic [IN_W-DROP_W:0]   rounded
);
  localparam int KEEP_W = IN_W - DROP_W;
  localparam logic [DROP_W-1:0] HALF = {1'b1, {(DROP_W-1){1'b0}}};

  logic [KEEP_W-1:0] kept;
  logic [DROP_W-1:0] tail;
  logic              bump;

  always_comb begin
    kept    = din[IN_W-1:DROP_W];
    tail    = din[DROP_W-1:0];
    bump    = (tail > HALF) || ((tail == HALF) && kept[0]);
    rounded = {kept[KEEP_W-1], kept} + {{KEEP_W{1'b0}}, bump};
  end
endmodule

// File: rtl/ars_clamp.sv
// Saturates a signed word into OUT_W bits and flags when it had to.
module ars_clamp #(
  parameter int IN_W  = 41,
  parameter int OUT_W = 32
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout,
  output logic             ovf
);
  localparam int HEAD_W = IN_W - OUT_W + 1;

  logic [HEAD_W-1:0] head;
  logic              fits;

  always_comb begin
    head = din[IN_W-1:OUT_W-1];
    fits = (head == '0) || (&head);
    ovf  = !fits;
    dout = fits ? din[OUT_W-1:0] : {din[IN_W-1], {(OUT_W-1){~din[IN_W-1]}}};
  end
endmodule

// File: rtl/acc_store_rounder.sv
module acc_store_rounder
  import ars_pkg::*;
#(
  parameter int ACC_W    = 48,
  parameter int GUARD_W  = 8,
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ACC_W-1:0]  in_acc,
  input  logic              in_narrow,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WIDE_W-1:0] out_data,
  output logic              out_ovf
);
  localparam int FRAC_W      = ACC_W - GUARD_W;
  localparam int WIDE_DROP   = FRAC_W - WIDE_W;
  localparam int NARROW_DROP = FRAC_W - NARROW_W;

  logic [WIDE_W-1:0] lane_res [RS_LANES];
  logic              lane_ovf [RS_LANES];

  // One rounding/clamp lane per result size.
  for (genvar g = 0; g < RS_LANES; g++) begin : g_lane
    localparam int DROP  = (g == int'(RS_NARROW)) ? NARROW_DROP : WIDE_DROP;
    localparam int OUT_W = (g == int'(RS_NARROW)) ? NARROW_W : WIDE_W;
    localparam int RND_W = ACC_W - DROP + 1;

    logic [RND_W-1:0] rnd;
    logic [OUT_W-1:0] sat;
    logic             sat_ovf;

    ars_rne #(.IN_W(ACC_W), .DROP_W(DROP)) u_rne (
      .din     (in_acc),
      .rounded (rnd)
    );

    ars_clamp #(.IN_W(RND_W), .OUT_W(OUT_W)) u_clamp (
      .din  (rnd),
      .dout (sat),
      .ovf  (sat_ovf)
    );

    always_comb begin
      lane_res[g] = WIDE_W'($signed(sat));
      lane_ovf[g] = sat_ovf;
    end
  end

  logic   accept;
  rsize_e size_q;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ovf   <= 1'b0;
      size_q    <= RS_WIDE;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_data  <= lane_res[in_narrow];
        out_ovf   <= lane_ovf[in_narrow];
        size_q    <= rsize_e'(in_narrow);
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9: an accepted word is on the output after the next edge
  a_r9_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R10: stalled output holds its value and blocks input
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ovf)));

  a_r10_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8: narrow results are sign-extended
  a_r8_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && size_q == RS_NARROW) |->
      (out_data[WIDE_W-1:NARROW_W] == {(WIDE_W-NARROW_W){out_data[NARROW_W-1]}}));

  // R6/R7: a clamped result is one of the extreme fractions
  a_r6_r7_clamp_value: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |->
      ((size_q == RS_NARROW)
        ? (out_data == WIDE_W'($signed({1'b0, {(NARROW_W-1){1'b1}}})) ||
           out_data == WIDE_W'($signed({1'b1, {(NARROW_W-1){1'b0}}})))
        : (out_data == {1'b0, {(WIDE_W-1){1'b1}}} ||
           out_data == {1'b1, {(WIDE_W-1){1'b0}}})));
endmodule

// File: tb/acc_store_rounder_test.sv
module acc_store_rounder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] in_acc = '0;
  logic        in_narrow = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_ovf;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] d;
    logic        o;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  acc_store_rounder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_acc(in_acc), .in_narrow(in_narrow), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_ovf(out_ovf)
  );

  function automatic exp_t model(logic [47:0] a, logic nar, string tag);
    exp_t e;
    longint v, kept, rem, half, maxv, minv;
    int sh;
    sh   = nar ? 24 : 8;
    v    = longint'({{16{a[47]}}, a});
    kept = v >>> sh;
    rem  = v & ((64'sd1 <<< sh) - 1);
    half = 64'sd1 <<< (sh - 1);
    if (rem > half || (rem == half && kept[0])) kept = kept + 1;
    maxv = nar ? 64'sd32767 : 64'sd2147483647;
    minv = -maxv - 1;
    e.o = 1'b0;
    if (kept > maxv) begin kept = maxv; e.o = 1'b1; end
    if (kept < minv) begin kept = minv; e.o = 1'b1; end
    e.d = kept[31:0];
    e.tag = tag;
    return e;
  endfunction

  function automatic logic [47:0] mk_w(logic [31:0] k, logic [7:0] t);
    return {{8{k[31]}}, k, t};
  endfunction

  function automatic logic [47:0] mk_n(logic [15:0] k, logic [23:0] t);
    return {{8{k[15]}}, k, t};
  endfunction

  task automatic cycle(input logic v, input logic [47:0] a, input logic nar,
                       input string tag, output bit took);
    @(negedge clk);
    in_valid  = v;
    in_acc    = a;
    in_narrow = nar;
    out_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;
    #1;
    took = 1'b0;
    compared++;
    if (out_valid !== (q.size() != 0)) begin
      mismatched++;
      $display("FAIL R9 out_valid actual=%b expected=%b", out_valid, q.size() != 0);
    end
    if (out_valid && q.size() != 0) begin
      compared++;
      if (out_data !== q[0].d || out_ovf !== q[0].o) begin
        mismatched++;
        $display("FAIL %s (R10 if stalled) data/ovf actual=%h/%b expected=%h/%b",
                 q[0].tag, out_data, out_ovf, q[0].d, q[0].o);
      end
      if (!out_ready) begin
        compared++;
        if (in_ready !== 1'b0) begin
          mismatched++;
          $display("FAIL R10 in_ready actual=%b expected=0", in_ready);
        end
      end
      if (out_ready) void'(q.pop_front());
    end
    if (v && in_ready) begin
      q.push_back(model(a, nar, tag));
      took = 1'b1;
    end
  endtask

  task automatic send(input logic [47:0] a, input logic nar, input string tag);
    bit took;
    took = 1'b0;
    while (!took) cycle(1'b1, a, nar, tag, took);
  endtask

  task automatic idle(input int n);
    bit took;
    for (int i = 0; i < n; i++) cycle(1'b0, '0, 1'b0, "idle", took);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      mismatched++;
      $display("FAIL watchdog actual=%0d cycles expected<=20000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (out_valid !== 1'b0) begin
      mismatched++;
      $display("FAIL R11 out_valid in reset actual=%b expected=0", out_valid);
    end
    rst_n = 1'b1;
    idle(2);

    // R3 below half, R1/R2 field position
    send(mk_w(32'h12345678, 8'h7F), 1'b0, "R1_R3");
    send(mk_n(16'h1234, 24'h7FFFFF), 1'b1, "R2_R3");
    // R4 above half
    send(mk_w(32'h12345678, 8'h81), 1'b0, "R1_R4");
    send(mk_n(16'h1234, 24'h800001), 1'b1, "R2_R4");
    // R5 exact half, even and odd kept
    send(mk_w(32'h12345678, 8'h80), 1'b0, "R5_even_w");
    send(mk_w(32'h12345679, 8'h80), 1'b0, "R5_odd_w");
    send(mk_n(16'h1234, 24'h800000), 1'b1, "R5_even_n");
    send(mk_n(16'h1235, 24'h800000), 1'b1, "R5_odd_n");
    send(mk_w(32'hFFFFFFFF, 8'h80), 1'b0, "R5_neg_odd");
    // R6 positive clamp
    send(48'h01_0000_0000_00, 1'b0, "R6_guard_w");
    send(mk_w(32'h7FFFFFFF, 8'h81), 1'b0, "R6_round_w");
    send(mk_n(16'h7FFF, 24'h800000), 1'b1, "R6_round_n");
    send(48'h00_8000_0000_00, 1'b1, "R6_field_n");
    // R7 negative clamp and in-range extremes
    send(48'hFE_0000_0000_00, 1'b0, "R7_guard_w");
    send(48'hFF_0000_0000_00, 1'b1, "R7_field_n");
    send(mk_w(32'h80000000, 8'h00), 1'b0, "R7_minfit_w");
    // R8 sign extension of narrow result
    send(mk_n(16'h8001, 24'h123456), 1'b1, "R8_neg_n");
    idle(3);

    // R9/R10 streams under back-pressure with mixed sizes
    stall_mode = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [47:0] a;
      a = {$urandom, $urandom};
      if (i % 4 == 0) a[47:40] = {8{a[39]}};
      send(a, logic'(i % 2), "R9_R10_stream");
      if (i % 7 == 0) idle(1);
    end
    stall_mode = 1'b0;
    idle(5);
    finish_run();
  end
endmodule